// File: doc/BRIEF.md
# Nine-Bit Rewindable FIFO Buffer

This block is a first-in/first-out store for 9-bit words. The extra ninth bit lets a parity bit or a control marker travel beside each byte. A single clock samples four active-low controls: a write strobe, a read strobe, a synchronous reset and a rewind request. Two circular pointers pick the storage locations, so the block has no address port. Every accepted write stores one word at the write pointer. Every accepted read moves the word at the read pointer onto the registered read-data output. The number of stored words selects one of four occupancy states, and these states drive three active-low flags: empty, full and "more than half full".

The rewind request moves the read pointer back to the first location. The buffer then reports every word written since the last reset as stored again, so a message can be sent a second time without the producer supplying it again. The empty flag blocks reads and the full flag blocks writes, so the buffer can neither underflow nor overflow. A read and a write may be requested in the same cycle.

The occupancy state machine has four states. `OCC_EMPTY` holds no words. `OCC_LOWER` holds 1 to DEPTH/2 words. `OCC_UPPER` holds more than DEPTH/2 words but fewer than DEPTH. `OCC_FULL` holds DEPTH words. At each clock edge the next state comes from the next word count:
- A write alone moves the count up by one: EMPTY→LOWER, LOWER→UPPER across the half mark, UPPER→FULL.
- A read alone moves the count down by one along the same path in reverse.
- A read and a write together keep the state.
- A rewind jumps from any state to the state for the words written since reset.
- Reset returns to EMPTY from any state.

Top module: `fifo_rt`

## Requirements
- R1: Words leave in the order they entered, all 9 bits intact. An accepted read places its word on `rd_data` at the clock edge that samples the read. `rd_data` keeps its value in every cycle without an accepted read.
- R2: DEPTH is a power of two from 512 to 16,384. Exactly DEPTH accepted writes with no reads bring the buffer to full.
- R3: A write is accepted when `wr_n` is 0 and the buffer is not full. A write while full is ignored: no stored word changes and the flags do not change.
- R4: A read while empty is ignored: `rd_data` and the flags do not change.
- R5: A read and a write in the same cycle are both accepted when the buffer is neither empty nor full, and the count stays the same. When empty, only the write is accepted. When full, only the read is accepted.
- R6: When `rt_n` is 0 at a clock edge, the read pointer returns to the first location. The count becomes the number of words written since reset (at most DEPTH). Read and write strobes in that cycle are ignored.
- R7: `empty_n` is 0 exactly when the count is 0. `full_n` is 0 exactly when the count is DEPTH.
- R8: `half_n` is 0 exactly when the count is greater than DEPTH/2.
- R9: When `rst_n` is 0 at a clock edge, both pointers and the count clear. `empty_n` becomes 0, `full_n` and `half_n` become 1, and `rd_data` becomes 0. Reset takes priority over every other input.
- R10: The flags come from the occupancy state register (EMPTY, LOWER, UPPER, FULL). They change at the same edge as the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind (retransmit) request, active low |
| wr_data | input | 9 | Word to store |
| rd_data | output | 9 | Last word read, registered |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The bench writes a word while the buffer is full and later reads back the oldest word. A design that let the write through would overwrite that word, or would wrap the count so that the buffer reports empty. It fills the buffer to exactly DEPTH words, drains it, and then issues a rewind. A pointer without a wrap bit would rebuild a count of zero here and report empty instead of full. It also checks the half flag at DEPTH/2 and DEPTH/2+1 words, where a comparison off by one would switch the flag one word early or late. Finally it issues a rewind together with live read and write strobes. A design that did not give the rewind priority would store an extra word or lose a word when the data is read again.

// File: rtl/fifo_rt_pkg.sv
`timescale 1ns/1ps
package fifo_rt_pkg;

    // Width of one stored word: a byte plus one side bit.
    localparam int WORD_W = 9;

    // Occupancy classes that drive the status flags.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_LOWER = 2'd1,
        OCC_UPPER = 2'd2,
        OCC_FULL  = 2'd3
    } occ_state_t;

endpackage

// File: rtl/fifo_rt_ring_ptr.sv
`timescale 1ns/1ps
// Circular pointer: steps by one per accepted operation and wraps at 2**PTR_W.
module fifo_rt_ring_ptr #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             rewind,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (rewind) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + PTR_W'(1);
        end
    end

    // R6: a rewind puts the pointer on the first location
    a_r6_rewind_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (ptr == '0));

    // R1: without step or rewind the pointer holds
    a_r1_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !rewind) |=> $stable(ptr));

endmodule

// File: rtl/fifo_rt_store.sv
`timescale 1ns/1ps
// Word storage with a registered read port.
module fifo_rt_store
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              do_rd,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Array without reset so that it maps onto a plain RAM.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (do_rd) begin
            rdata <= mem[raddr];
        end
    end

    // R4: with no accepted read the output word holds
    a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> $stable(rdata));

endmodule

// File: rtl/fifo_rt_ctrl.sv
`timescale 1ns/1ps
// Strobe decode, occupancy count and occupancy state machine.
module fifo_rt_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    input  logic [CNT_W-1:0] wr_total,
    output logic             do_wr,
    output logic             do_rd,
    output logic             do_rt,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    occ_state_t       state, state_nxt;
    logic [CNT_W-1:0] count, count_nxt;

    function automatic occ_state_t classify(input logic [CNT_W-1:0] c);
        if (c == '0)            return OCC_EMPTY;
        else if (c == FULL_CNT) return OCC_FULL;
        else if (c > HALF_CNT)  return OCC_UPPER;
        else                    return OCC_LOWER;
    endfunction

    // Request decode: rewind wins over strobes, state gates the strobes.
    always_comb begin
        do_rt = rst_n && !rt_n;
        do_wr = rst_n && rt_n && !wr_n && (state != OCC_FULL);
        do_rd = rst_n && rt_n && !rd_n && (state != OCC_EMPTY);
    end

    always_comb begin
        if (do_rt) begin
            count_nxt = wr_total;
        end else begin
            count_nxt = count + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
        state_nxt = classify(count_nxt);
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    // Output process: flags from the state only.
    always_comb begin
        empty_n = 1'b1;
        full_n  = 1'b1;
        half_n  = 1'b1;
        unique case (state)
            OCC_EMPTY: empty_n = 1'b0;
            OCC_LOWER: ;
            OCC_UPPER: half_n  = 1'b0;
            OCC_FULL: begin
                full_n = 1'b0;
                half_n = 1'b0;
            end
        endcase
    end

    // R3: a lone write into a full buffer leaves the count alone
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_n && rd_n && rt_n) |=> $stable(count));

    // R4: a lone read from an empty buffer leaves the count alone
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_n && wr_n && rt_n) |=> $stable(count));

    // R5: read and write together in a partly filled buffer keep the count
    a_r5_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_n && full_n && !wr_n && !rd_n && rt_n) |=> $stable(count));

    // R7: the count never exceeds the depth, and empty and full never coexist
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= FULL_CNT) && (empty_n || full_n));

    // R8: the half flag implies the buffer is not empty
    a_r8_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !half_n |-> empty_n);

    // R6: after a rewind the count equals the words written since reset
    a_r6_rewind_count: assert property (@(posedge clk) disable iff (!rst_n)
        do_rt |=> (count == $past(wr_total)));

endmodule

// File: rtl/fifo_rt.sv
`timescale 1ns/1ps
// Top: nine-bit FIFO with rewind and occupancy flags.
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              do_wr, do_rd, do_rt;
    logic [CNT_W-1:0]  wptr;   // carries a wrap bit: words written since reset
    logic [ADDR_W-1:0] rptr;

    fifo_rt_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .rt_n     (rt_n),
        .wr_total (wptr),
        .do_wr    (do_wr),
        .do_rd    (do_rd),
        .do_rt    (do_rt),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .half_n   (half_n)
    );

    fifo_rt_ring_ptr #(
        .PTR_W (CNT_W)
    ) u_wptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (do_wr),
        .rewind (1'b0),
        .ptr    (wptr)
    );

    fifo_rt_ring_ptr #(
        .PTR_W (ADDR_W)
    ) u_rptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (do_rd),
        .rewind (do_rt),
        .ptr    (rptr)
    );

    fifo_rt_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .do_wr (do_wr),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (wr_data),
        .do_rd (do_rd),
        .raddr (rptr),
        .rdata (rd_data)
    );

endmodule

// File: tb/fifo_rt_test.sv
`timescale 1ns/1ps
module fifo_rt_test;

    localparam int DEPTH = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       empty_n, full_n, half_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    fifo_rt #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .wr_data(wr_data), .rd_data(rd_data),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    // Vector: {wr_n, rd_n, rt_n, wr_data[8:0], exp empty_n, full_n, half_n, exp rd_data[8:0]}
    localparam logic [23:0] VEC [12] = '{
        {1'b0,1'b1,1'b1,9'h1A5, 1'b1,1'b1,1'b1, 9'h000},  // write, R1
        {1'b0,1'b1,1'b1,9'h033, 1'b1,1'b1,1'b1, 9'h000},  // write
        {1'b1,1'b0,1'b1,9'h000, 1'b1,1'b1,1'b1, 9'h1A5},  // read oldest, R1
        {1'b0,1'b0,1'b1,9'h0FF, 1'b1,1'b1,1'b1, 9'h033},  // both, R5
        {1'b1,1'b0,1'b1,9'h000, 1'b0,1'b1,1'b1, 9'h0FF},  // read last, R7 empty
        {1'b1,1'b0,1'b1,9'h000, 1'b0,1'b1,1'b1, 9'h0FF},  // read while empty, R4
        {1'b0,1'b0,1'b1,9'h100, 1'b1,1'b1,1'b1, 9'h0FF},  // both while empty, R5
        {1'b1,1'b1,1'b0,9'h000, 1'b1,1'b1,1'b1, 9'h0FF},  // rewind: 4 words, R6
        {1'b1,1'b0,1'b1,9'h000, 1'b1,1'b1,1'b1, 9'h1A5},  // replay, R6
        {1'b1,1'b0,1'b1,9'h000, 1'b1,1'b1,1'b1, 9'h033},
        {1'b1,1'b0,1'b1,9'h000, 1'b1,1'b1,1'b1, 9'h0FF},
        {1'b1,1'b0,1'b1,9'h000, 1'b0,1'b1,1'b1, 9'h100}
    };

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) & 511);
    endfunction

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_word(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input int cnt);
        chk_bit({tag, " R7 empty_n"}, empty_n, cnt != 0);
        chk_bit({tag, " R7 full_n"}, full_n, cnt != DEPTH);
        chk_bit({tag, " R8 half_n"}, half_n, !(cnt > DEPTH / 2));
    endtask

    // Drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic w, input logic r, input logic t, input logic [8:0] d);
        @(negedge clk);
        wr_n = w; rd_n = r; rt_n = t; wr_data = d;
        @(posedge clk);
        #1;
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_bit("R9 reset empty_n", empty_n, 1'b0);
        chk_bit("R9 reset full_n", full_n, 1'b1);
        chk_bit("R9 reset half_n", half_n, 1'b1);
        chk_word("R9 reset rd_data", rd_data, 9'h000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk
        for (int i = 0; i < 12; i++) begin
            step(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:12]);
            chk_bit($sformatf("table %0d R7 empty_n", i), empty_n, VEC[i][11]);
            chk_bit($sformatf("table %0d R7 full_n", i), full_n, VEC[i][10]);
            chk_bit($sformatf("table %0d R8 half_n", i), half_n, VEC[i][9]);
            chk_word($sformatf("table %0d R1 rd_data", i), rd_data, VEC[i][8:0]);
        end

        // Reset from a non-empty state clears everything
        step(1'b0, 1'b1, 1'b1, 9'h155);
        step(1'b1, 1'b0, 1'b1, 9'h000);
        step(1'b0, 1'b1, 1'b1, 9'h0AA);
        do_reset();
        step(1'b1, 1'b0, 1'b1, 9'h000);
        chk_word("R9 R4 read after reset ignored", rd_data, 9'h000);
        chk_bit("R9 still empty", empty_n, 1'b0);

        // Fill to exactly DEPTH, flags every step (R2, R7, R8)
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b1, 1'b1, pat(i));
            chk_flags($sformatf("R2 fill %0d", i + 1), i + 1);
        end

        // Write while full is ignored (R3)
        step(1'b0, 1'b1, 1'b1, 9'h1FF);
        chk_flags("R3 write when full", DEPTH);

        // Read and write while full: only the read (R5)
        step(1'b0, 1'b0, 1'b1, 9'h1FF);
        chk_word("R5 R3 full both data", rd_data, pat(0));
        chk_flags("R5 full both", DEPTH - 1);

        // Drain, checking order and flags (R1)
        for (int i = 1; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 1'b1, 9'h000);
            chk_word($sformatf("R1 drain %0d", i), rd_data, pat(i));
            chk_flags($sformatf("R1 drain %0d", i), DEPTH - 1 - i);
        end

        // Read while empty is ignored (R4)
        step(1'b1, 1'b0, 1'b1, 9'h000);
        chk_word("R4 empty read data", rd_data, pat(DEPTH - 1));
        chk_flags("R4 empty read", 0);

        // Rewind after exactly DEPTH writes reports full (R6)
        step(1'b1, 1'b1, 1'b0, 9'h000);
        chk_flags("R6 rewind at depth", DEPTH);
        step(1'b1, 1'b0, 1'b1, 9'h000);
        chk_word("R6 replay first", rd_data, pat(0));
        chk_flags("R6 replay first", DEPTH - 1);

        // Rewind beats live strobes (R6)
        do_reset();
        step(1'b0, 1'b1, 1'b1, pat(0));
        step(1'b0, 1'b1, 1'b1, pat(1));
        step(1'b0, 1'b0, 1'b0, 9'h0AA);
        chk_word("R6 strobes ignored data", rd_data, 9'h000);
        chk_flags("R6 strobes ignored", 2);
        step(1'b1, 1'b0, 1'b1, 9'h000);
        chk_word("R6 replay word 0", rd_data, pat(0));
        step(1'b1, 1'b0, 1'b1, 9'h000);
        chk_word("R6 replay word 1", rd_data, pat(1));
        chk_flags("R6 replay end", 0);

        // State tracks through a half-way crossing from the top (R10)
        for (int i = 0; i < DEPTH / 2 + 1; i++) begin
            step(1'b0, 1'b1, 1'b1, pat(i));
        end
        chk_flags("R10 upper", DEPTH / 2 + 1);
        step(1'b1, 1'b0, 1'b1, 9'h000);
        chk_flags("R10 back to lower", DEPTH / 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule